// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits over several clock cycles, using a single accumulator of `2W+1` bits. A start request loads the multiplier into the low half of the accumulator and clears the upper part. Each step then looks at the accumulator's least significant bit. When that bit is 1, the multiplicand is first added into the upper part, and the add is followed by a one-place right shift of the whole accumulator. When that bit is 0, the step is only the shift. After `W` shifts, the low `2W` bits hold the product.

Control is split into two parts. An add/shift sequencer chooses, for each step, between add-then-shift and shift-only. A separate step counter counts the shifts and signals the last one. The sequencer stops on that signal and raises a one-cycle completion pulse. The multiplicand is captured when a start is accepted, unless the capture is configured away. While an operation is running, the start input is disregarded.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `done` is 0 and `product` is 0.
- R2: A high `start` is accepted at a clock edge only when no operation is in progress. This includes the cycle in which `done` is high. Acceptance loads the multiplier into the low `W` accumulator bits and clears the upper `W+1` bits.
- R3: On completion, `product` equals the unsigned product `mplier * mcand` of the operands present at the accepting edge, as a `2W`-bit value.
- R4: `done` is high for exactly one cycle. It rises after the clock edge that is `W + k` edges past the accepting edge, where `k` is the number of 1 bits in the multiplier.
- R5: A multiplier bit of 1 costs one add cycle followed by one shift cycle. A bit of 0 costs one shift cycle. An add happens only when the current accumulator bit 0 is 1.
- R6: `start` has no effect while an operation is in progress. Neither the timing of `done` nor the resulting product changes.
- R7: With `LATCH_MCAND` = 1 (the default), changes on `mcand` after the accepting edge do not affect the product.
- R8: After completion, `product` holds its value until the next start is accepted.
- R9: The step counter ends the operation after exactly `W` shifts and never counts past `W-1`.
- R10: The carry out of each add is kept in the top accumulator bit. For example, all-ones operands give `(2^W-1)^2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication |
| mplier | input | W | Multiplier operand, unsigned |
| mcand | input | W | Multiplicand operand, unsigned |
| product | output | 2W | Low `2W` bits of the accumulator |
| done | output | 1 | One-cycle pulse when the product is final |

## Verification
The hardest case to reach from the ports is a start request that lands inside a running operation while the operands also change. The stimulus produces it by pulsing `start` and rewriting both operands in the middle of an operation. The reference model then must show `done` at the cycle and with the value set by the first request. A second difficult case is a start held high through the completion cycle: the next operation must begin back to back, with no idle cycle. An exhaustive sweep over all operand pairs covers every add/shift pattern and the carry into the top bit.

// File: rtl/shmul_pkg.sv
package shmul_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_TEST  = 2'd1,
      SQ_SHIFT = 2'd2
   } sq_state_t;
endpackage

// File: rtl/shmul_step_counter.sv
module shmul_step_counter #(
   parameter int W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic sh,
   output logic last
);
   localparam int CW = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

   logic [CW-1:0] cnt;

   assign last = (cnt == LAST_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (sh && last) cnt <= '0;
      else if (sh)         cnt <= cnt + 1'b1;
   end

   // R9: counter bounded and wraps after the final shift
   assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST_CNT);
   assert_cnt_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sh && last && !clr) |=> (cnt == '0));
endmodule

// File: rtl/shmul_seq.sv
module shmul_seq
   import shmul_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic m,
   input  logic last,
   output logic ld,
   output logic ad,
   output logic sh,
   output logic done
);
   sq_state_t state, state_nx;

   always_comb begin
      state_nx = state;
      ld = 1'b0;
      ad = 1'b0;
      sh = 1'b0;
      unique case (state)
         SQ_IDLE: begin
            if (start) begin
               ld       = 1'b1;
               state_nx = SQ_TEST;
            end
         end
         SQ_TEST: begin
            if (m) begin
               ad       = 1'b1;
               state_nx = SQ_SHIFT;
            end else begin
               sh = 1'b1;
               if (last) state_nx = SQ_IDLE;
            end
         end
         SQ_SHIFT: begin
            sh       = 1'b1;
            state_nx = last ? SQ_IDLE : SQ_TEST;
         end
         default: state_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         done  <= 1'b0;
      end else begin
         state <= state_nx;
         done  <= sh && last;
      end
   end

   // R4: completion is a single-cycle pulse
   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R5: an add only when the inspected accumulator bit is 1
   assert_add_on_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ad |-> m);
   // R6: a start seen mid-operation is not loaded on the next edge
   assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ad || (sh && !last)) |=> !ld);
endmodule

// File: rtl/shmul_datapath.sv
module shmul_datapath #(
   parameter int W           = 4,
   parameter bit LATCH_MCAND = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld,
   input  logic           ad,
   input  logic           sh,
   input  logic [W-1:0]   mplier,
   input  logic [W-1:0]   mcand,
   output logic           m,
   output logic [2*W-1:0] product
);
   localparam int PW = 2 * W;
   localparam int AW = PW + 1;

   logic [AW-1:0] acc;
   logic [W-1:0]  mc_use;
   logic [W:0]    sum;

   generate
      if (LATCH_MCAND) begin : g_mc_reg
         logic [W-1:0] mc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  mc_q <= '0;
            else if (ld) mc_q <= mcand;
         end
         assign mc_use = mc_q;
      end else begin : g_mc_wire
         assign mc_use = mcand;
      end
   endgenerate

   assign sum     = {1'b0, acc[PW-1:W]} + {1'b0, mc_use};
   assign m       = acc[0];
   assign product = acc[PW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc <= '0;
      else if (ld) acc <= {{(W+1){1'b0}}, mplier};
      else if (ad) acc <= {sum, acc[W-1:0]};
      else if (sh) acc <= {1'b0, acc[AW-1:1]};
   end

   // R2: load clears the upper part and places the multiplier low
   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (acc[AW-1:W] == '0) && (acc[W-1:0] == $past(mplier)));
   // R10: carry bit is free before every add
   assert_carry_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ad |-> !acc[AW-1]);
   // R5: shift moves the whole accumulator one place right
   assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sh && !ld && !ad) |=> (acc == {1'b0, $past(acc[AW-1:1])}));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
   parameter int W           = 4,
   parameter bit LATCH_MCAND = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [W-1:0]   mplier,
   input  logic [W-1:0]   mcand,
   output logic [2*W-1:0] product,
   output logic           done
);
   generate
      if (W < 2) begin : g_bad_width
         $error("shift_add_mul: W must be at least 2");
      end
   endgenerate

   logic ld, ad, sh, m, last;

   shmul_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .m     (m),
      .last  (last),
      .ld    (ld),
      .ad    (ad),
      .sh    (sh),
      .done  (done)
   );

   shmul_step_counter #(.W(W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ld),
      .sh    (sh),
      .last  (last)
   );

   shmul_datapath #(.W(W), .LATCH_MCAND(LATCH_MCAND)) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (ld),
      .ad      (ad),
      .sh      (sh),
      .mplier  (mplier),
      .mcand   (mcand),
      .m       (m),
      .product (product)
   );
endmodule

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;
   localparam int W  = 4;
   localparam int PW = 2 * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  mplier = '0;
   logic [W-1:0]  mcand = '0;
   logic [PW-1:0] product;
   logic          done;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit finished = 0;

   // reference model state
   int rem = 0;
   bit exp_done = 0;
   int exp_prod = 0;
   bit prod_valid = 1;
   int completions = 0;

   shift_add_mul #(.W(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mplier(mplier), .mcand(mcand), .product(product), .done(done)
   );

   always #5 clk = ~clk;

   function automatic int ones(input logic [W-1:0] v);
      int n = 0;
      for (int i = 0; i < W; i++) n += int'(v[i]);
      return n;
   endfunction

   // R2 R4 R5 R6 R7: behavioural timing/product model
   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         rem = 0; exp_done = 0; exp_prod = 0; prod_valid = 1;
      end else begin
         exp_done = 0;
         if (rem > 0) begin
            rem--;
            if (rem == 0) begin
               exp_done = 1; prod_valid = 1; completions++;
            end
         end else if (start) begin
            rem = W + ones(mplier);
            exp_prod = int'(mplier) * int'(mcand);
            prod_valid = 0;
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if (done !== exp_done) begin
            errors++;
            $display("FAIL R4/R6 done: actual=%0b expected=%0b at cycle %0d", done, exp_done, cycles);
         end
         if (prod_valid) begin
            checks++;
            if (int'(product) != exp_prod) begin
               errors++;
               $display("FAIL R3/R8/R10 product: actual=%0d expected=%0d at cycle %0d", product, exp_prod, cycles);
            end
         end
      end
   end

   task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      mplier = a; mcand = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (rem != 0) @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      #1;
      repeat (3) @(negedge clk);
      checks++;
      if (done !== 1'b0 || product !== '0) begin
         errors++;
         $display("FAIL R1 reset: actual done=%0b product=%0d expected 0/0", done, product);
      end
      rst_n = 1'b1;
      // R3 R5 R10 directed corners
      run_op(4'd0, 4'd9);
      run_op(4'd9, 4'd0);
      run_op(4'd15, 4'd15);
      run_op(4'd1, 4'd1);
      run_op(4'd5, 4'd3);
      run_op(4'd10, 4'd6);
      // R8: product holds across idle cycles
      repeat (6) @(negedge clk);
      // R6 R7: start pulses and operand changes mid-operation
      @(negedge clk);
      mplier = 4'd13; mcand = 4'd11; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      mplier = 4'd2; mcand = 4'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0; mcand = 4'd1;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (rem != 0) @(negedge clk);
      // R2 R4: start held high through completion gives back-to-back ops
      mplier = 4'd7; mcand = 4'd9; start = 1'b1;
      repeat (30) @(negedge clk);
      start = 1'b0;
      while (rem != 0) @(negedge clk);
      // R3: exhaustive sweep
      for (int a = 0; a < (1 << W); a++)
         for (int b = 0; b < (1 << W); b++)
            run_op(W'(a), W'(b));
      repeat (3) @(negedge clk);
      checks++;
      if (completions < 260) begin
         errors++;
         $display("FAIL R4 completions: actual=%0d expected>=260", completions);
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait (cycles > 100000);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule